// File: doc/BRIEF.md
# Queue Accumulator Channel with Interrupt Pacing

This block watches a window of queues held by an external queue manager. It pops every descriptor that shows up in them and appends each descriptor address to a list buffer in host memory. When the list reaches its programmed length, or a pacing timer runs out, it raises an interrupt. The window is either one queue or a run of up to `NUM_Q` contiguous queues that starts at a programmable base queue number. Non-empty queues are served in round-robin order, so one busy queue cannot starve the others.

The pacing mode selects how often the interrupt fires:

- mode 0 fires only when the list is full;
- mode 1 runs the timer from the last interrupt;
- mode 2 starts the timer at the first descriptor after an interrupt;
- mode 3 restarts the timer at every descriptor.

The delay is given in microseconds. A prescaler set by the clock frequency parameter produces the 1 µs tick. Once the interrupt is raised, the channel freezes the list until the host acknowledges. It then starts over at entry zero.

Top module: `qacc_channel`

## Requirements
- R1: After synchronous reset `pop_req`, `list_wr_en` and `irq` are low.
- R2: With `cfg_multi`=1 the channel serves queues `cfg_base_q`..`cfg_base_q+NUM_Q-1`, where bit k of `q_nonempty` belongs to queue `cfg_base_q+k`. With `cfg_multi`=0 it serves only `cfg_base_q` (bit 0), and the other bits are ignored. `pop_qid` carries the absolute queue number.
- R3: Selection is round-robin. After a pop from offset k, the next search begins at offset k+1 and wraps at `NUM_Q`.
- R4: `pop_req` is a one-cycle pulse, and at most one pop is outstanding. No new pop is issued before `pop_ack` returns.
- R5: A response with a non-zero `pop_desc` is written on the next cycle at `list_wr_idx` equal to the current fill count, and the fill count then rises by one. A zero address is a null pop: nothing is written and the fill count does not change.
- R6: The write that brings the fill count to `cfg_list_len` raises `irq` on the same clock edge as that write.
- R7: `irq` stays high until `host_ack` is sampled high. It then drops on the next edge and the fill count returns to 0. `host_ack` while `irq` is low has no effect.
- R8: While `irq` is high, no pop is issued and no list write happens.
- R9: The pacing timer advances once per tick, and a tick comes every `CLK_MHZ` clocks. The delay `cfg_delay_us` is counted in ticks.
- R10: In mode 0 (`cfg_pace_mode`=0) the timer never raises `irq`.
- R11: In mode 1 the timer runs from reset and from each acknowledge. An expiry with a non-empty list raises `irq`. An expiry with an empty list only restarts the timer.
- R12: In mode 2 the timer starts at the first descriptor after an interrupt. Later descriptors do not restart it.
- R13: In mode 3 every accepted descriptor restarts the timer.
- R14: An expiry that happens while a pop is outstanding is held until the response has landed. That descriptor is therefore in the list before `irq` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Allows pops to be issued |
| cfg_multi | input | 1 | 1: window of NUM_Q queues, 0: base queue only |
| cfg_base_q | input | QID_W | First queue number of the window |
| cfg_list_len | input | LIST_W | List length in entries |
| cfg_pace_mode | input | 2 | Pacing mode 0..3 |
| cfg_delay_us | input | DLY_W | Pacing delay in microseconds |
| q_nonempty | input | NUM_Q | Per-queue non-empty flags relative to base |
| pop_req | output | 1 | Pop request pulse |
| pop_qid | output | QID_W | Queue to pop |
| pop_ack | input | 1 | Pop response valid |
| pop_desc | input | ADDR_W | Popped descriptor address, 0 for none |
| list_wr_en | output | 1 | List buffer write strobe |
| list_wr_idx | output | LIST_W | List entry index |
| list_wr_data | output | ADDR_W | Descriptor address written |
| irq | output | 1 | Interrupt to host, level |
| host_ack | input | 1 | Host acknowledge of the list |

## Verification
A landing pop response and a pacing expiry are the two events that compete for the same cycle. The bench provokes the collision in two ways. In one case it stretches the queue manager's latency past the delay, so the timer expires while a pop is still in flight. In the other it pushes descriptors at spacings shorter and longer than the delay in modes 2 and 3. A behavioural reference model, updated every clock, predicts on which edge `irq` rises and how many entries precede it. Directed checks confirm that the held expiry counts the in-flight descriptor, and that mode 3 restarts the timer while mode 2 does not.

// File: rtl/qacc_pkg.sv
package qacc_pkg;
    localparam int QID_W  = 14;
    localparam int ADDR_W = 32;
    localparam int LIST_W = 8;

    typedef enum logic [1:0] {
        PACE_FULL_ONLY   = 2'd0,
        PACE_SINCE_IRQ   = 2'd1,
        PACE_SINCE_FIRST = 2'd2,
        PACE_SINCE_LAST  = 2'd3
    } pace_e;

    typedef struct packed {
        logic              vld;
        logic [LIST_W-1:0] idx;
        logic [ADDR_W-1:0] data;
    } lwr_t;

    // True when one more entry reaches the programmed length
    function automatic logic reaches_len(input logic [LIST_W-1:0] fill,
                                         input logic [LIST_W-1:0] len);
        return ((LIST_W+1)'(fill) + (LIST_W+1)'(1)) >= (LIST_W+1)'(len);
    endfunction
endpackage

// File: rtl/qacc_tick.sv
module qacc_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/qacc_rr_pick.sv
module qacc_rr_pick #(
    parameter int N = 32,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic          any,
    output logic [PW-1:0] idx
);
    int p;
    always_comb begin
        any = 1'b0;
        idx = '0;
        p   = 0;
        // descending scan: the smallest offset from ptr wins
        for (int k = N - 1; k >= 0; k--) begin
            p = (int'(ptr) + k) % N;
            if (req[p[PW-1:0]]) begin
                any = 1'b1;
                idx = p[PW-1:0];
            end
        end
    end
endmodule

// File: rtl/qacc_pacer.sv
module qacc_pacer
    import qacc_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [1:0]       mode,
    input  logic [DLY_W-1:0] delay,
    input  logic             irq_nxt,
    input  logic             accept,
    input  logic             list_empty,
    output logic             done
);
    pace_e            m;
    logic             run;
    logic [DLY_W-1:0] tcnt;
    logic             adv;

    assign m    = pace_e'(mode);
    assign adv  = tick && (tcnt < delay);
    assign done = ((m == PACE_SINCE_IRQ) || run) && (tcnt >= delay);

    always_ff @(posedge clk) begin
        if (rst || irq_nxt) begin
            run  <= 1'b0;
            tcnt <= '0;
        end else begin
            case (m)
                PACE_SINCE_IRQ: begin
                    run <= 1'b0;
                    if (done && list_empty) tcnt <= '0;
                    else if (adv)           tcnt <= tcnt + 1'b1;
                end
                PACE_SINCE_FIRST: begin
                    if (!run) begin
                        if (accept) begin
                            run  <= 1'b1;
                            tcnt <= '0;
                        end
                    end else if (adv) tcnt <= tcnt + 1'b1;
                end
                PACE_SINCE_LAST: begin
                    if (accept) begin
                        run  <= 1'b1;
                        tcnt <= '0;
                    end else if (run && adv) tcnt <= tcnt + 1'b1;
                end
                default: begin
                    run  <= 1'b0;
                    tcnt <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/qacc_channel.sv
module qacc_channel
    import qacc_pkg::*;
#(
    parameter int NUM_Q   = 32,
    parameter int CLK_MHZ = 50,
    parameter int DLY_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic              cfg_multi,
    input  logic [QID_W-1:0]  cfg_base_q,
    input  logic [LIST_W-1:0] cfg_list_len,
    input  logic [1:0]        cfg_pace_mode,
    input  logic [DLY_W-1:0]  cfg_delay_us,
    input  logic [NUM_Q-1:0]  q_nonempty,
    output logic              pop_req,
    output logic [QID_W-1:0]  pop_qid,
    input  logic              pop_ack,
    input  logic [ADDR_W-1:0] pop_desc,
    output logic              list_wr_en,
    output logic [LIST_W-1:0] list_wr_idx,
    output logic [ADDR_W-1:0] list_wr_data,
    output logic              irq,
    input  logic              host_ack
);
    localparam int PW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

    logic [LIST_W-1:0] fill;
    logic              irq_q, busy, pop_req_q;
    logic [QID_W-1:0]  qid_q;
    logic [PW-1:0]     rr;
    lwr_t              wr_q;

    logic [NUM_Q-1:0]  watch;
    logic              cand_any;
    logic [PW-1:0]     cand_idx;
    logic              tick, timer_done;
    logic              accept, fire, full_hit, irq_nxt, issue;

    assign watch = q_nonempty & (cfg_multi ? {NUM_Q{1'b1}} : NUM_Q'(1));

    qacc_rr_pick #(.N(NUM_Q)) u_pick (
        .req (watch),
        .ptr (rr),
        .any (cand_any),
        .idx (cand_idx)
    );

    qacc_tick #(.DIV(CLK_MHZ)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    qacc_pacer #(.DLY_W(DLY_W)) u_pacer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .mode       (cfg_pace_mode),
        .delay      (cfg_delay_us),
        .irq_nxt    (irq_nxt),
        .accept     (accept),
        .list_empty (fill == '0),
        .done       (timer_done)
    );

    assign accept   = pop_ack && busy && (pop_desc != '0);
    assign fire     = timer_done && !busy && (fill != '0) && !irq_q;
    assign full_hit = accept && reaches_len(fill, cfg_list_len);
    assign irq_nxt  = irq_q ? !host_ack : (full_hit || fire);
    assign issue    = cfg_enable && !irq_q && !busy && !fire && cand_any
                      && (fill < cfg_list_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill      <= '0;
            irq_q     <= 1'b0;
            busy      <= 1'b0;
            pop_req_q <= 1'b0;
            qid_q     <= '0;
            rr        <= '0;
            wr_q      <= '0;
        end else begin
            irq_q     <= irq_nxt;
            pop_req_q <= issue;
            if (issue) begin
                busy  <= 1'b1;
                qid_q <= cfg_base_q + QID_W'(cand_idx);
                rr    <= (cand_idx == PW'(NUM_Q - 1)) ? '0 : cand_idx + 1'b1;
            end else if (pop_ack) begin
                busy  <= 1'b0;
            end
            if (irq_q && host_ack) fill <= '0;
            else if (accept)       fill <= fill + 1'b1;
            wr_q.vld  <= accept;
            wr_q.idx  <= fill;
            wr_q.data <= pop_desc;
        end
    end

    assign pop_req      = pop_req_q;
    assign pop_qid      = qid_q;
    assign list_wr_en   = wr_q.vld;
    assign list_wr_idx  = wr_q.idx;
    assign list_wr_data = wr_q.data;
    assign irq          = irq_q;
endmodule

// File: rtl/qacc_channel_chk.sv
module qacc_channel_chk
    import qacc_pkg::*;
#(
    parameter int NUM_Q = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_multi,
    input logic [QID_W-1:0]  cfg_base_q,
    input logic [LIST_W-1:0] cfg_list_len,
    input logic              pop_req,
    input logic [QID_W-1:0]  pop_qid,
    input logic              list_wr_en,
    input logic [LIST_W-1:0] list_wr_idx,
    input logic              irq,
    input logic              host_ack
);
    AST_POP_PULSE: assert property (@(posedge clk) disable iff (rst) pop_req |=> !pop_req); // R4
    AST_NO_POP_IRQ: assert property (@(posedge clk) disable iff (rst) irq |-> !pop_req); // R8
    AST_NO_WR_IRQ: assert property (@(posedge clk) disable iff (rst) (irq && $past(irq)) |-> !list_wr_en); // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst) (irq && !host_ack) |=> irq); // R7
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst) (irq && host_ack) |=> !irq); // R7
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst) list_wr_en |-> (list_wr_idx < cfg_list_len)); // R5
    AST_FULL_IRQ: assert property (@(posedge clk) disable iff (rst) (list_wr_en && ((LIST_W+1)'(list_wr_idx) + (LIST_W+1)'(1) == (LIST_W+1)'(cfg_list_len))) |-> irq); // R6
    AST_QID_WINDOW: assert property (@(posedge clk) disable iff (rst) pop_req |-> ((pop_qid - cfg_base_q) < (cfg_multi ? QID_W'(NUM_Q) : QID_W'(1)))); // R2
endmodule

bind qacc_channel qacc_channel_chk #(.NUM_Q(NUM_Q)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_multi    (cfg_multi),
    .cfg_base_q   (cfg_base_q),
    .cfg_list_len (cfg_list_len),
    .pop_req      (pop_req),
    .pop_qid      (pop_qid),
    .list_wr_en   (list_wr_en),
    .list_wr_idx  (list_wr_idx),
    .irq          (irq),
    .host_ack     (host_ack)
);

// File: tb/qacc_channel_bench.sv
module qacc_channel_bench;
    import qacc_pkg::*;
    localparam int NQ  = 32;
    localparam int MHZ = 50;
    localparam int DW  = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst = 1'b1, en = 1'b0, multi = 1'b1, pop_ack = 1'b0, host_ack = 1'b0;
    logic [QID_W-1:0]  base = 14'd100;
    logic [LIST_W-1:0] len = 8'd4;
    logic [1:0]        mode = 2'd0;
    logic [DW-1:0]     dly = '0;
    logic [NQ-1:0]     nonempty = '0;
    logic [ADDR_W-1:0] pop_desc = '0;
    logic              pop_req, wr_en, irq;
    logic [QID_W-1:0]  pop_qid;
    logic [LIST_W-1:0] wr_idx;
    logic [ADDR_W-1:0] wr_data;

    qacc_channel #(.NUM_Q(NQ), .CLK_MHZ(MHZ), .DLY_W(DW)) u_qacc_channel (
        .clk(clk), .rst(rst), .cfg_enable(en), .cfg_multi(multi), .cfg_base_q(base),
        .cfg_list_len(len), .cfg_pace_mode(mode), .cfg_delay_us(dly),
        .q_nonempty(nonempty), .pop_req(pop_req), .pop_qid(pop_qid),
        .pop_ack(pop_ack), .pop_desc(pop_desc), .list_wr_en(wr_en),
        .list_wr_idx(wr_idx), .list_wr_data(wr_data), .irq(irq), .host_ack(host_ack)
    );

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // queue manager contents
    logic [ADDR_W-1:0] qs [NQ][$];
    int  qm_lat = 0, qm_wait = 0, qm_off = 0;
    bit  qm_pend = 0, force_null = 0;
    task automatic refresh();
        for (int i = 0; i < NQ; i++) nonempty[i] = (qs[i].size() > 0);
    endtask
    task automatic push(input int off, input logic [ADDR_W-1:0] d);
        qs[off].push_back(d);
        refresh();
    endtask

    // reference model state
    int   m_fill, m_rr, m_ps, m_tc, m_widx;
    bit   m_irq, m_busy, m_run, m_preq, m_wr;
    logic [QID_W-1:0]  m_qid;
    logic [ADDR_W-1:0] m_wdata;

    always @(posedge clk) begin : model
        bit tick, done, fire, acc, full, irqn, issue;
        int pick;
        if (rst) begin
            m_fill = 0; m_rr = 0; m_ps = 0; m_tc = 0; m_widx = 0;
            m_irq = 0; m_busy = 0; m_run = 0; m_preq = 0; m_wr = 0;
            m_qid = '0; m_wdata = '0;
        end else begin
            tick  = (m_ps == MHZ - 1);
            done  = (mode == 2'd1 || m_run) && (m_tc >= int'(dly));
            fire  = done && !m_busy && m_fill != 0 && !m_irq;
            acc   = pop_ack && m_busy && pop_desc != 0;
            full  = acc && (m_fill + 1 >= int'(len));
            irqn  = m_irq ? !host_ack : (full || fire);
            pick  = -1;
            for (int k = 0; k < NQ; k++) begin
                int p;
                p = (m_rr + k) % NQ;
                if (pick < 0 && nonempty[p] && (multi || p == 0)) pick = p;
            end
            issue = en && !m_irq && !m_busy && !fire && pick >= 0 && m_fill < int'(len);
            if (irqn) begin
                m_run = 0; m_tc = 0;
            end else begin
                case (mode)
                    2'd1: begin
                        m_run = 0;
                        if (done && m_fill == 0) m_tc = 0;
                        else if (tick && m_tc < int'(dly)) m_tc++;
                    end
                    2'd2: begin
                        if (!m_run) begin
                            if (acc) begin m_run = 1; m_tc = 0; end
                        end else if (tick && m_tc < int'(dly)) m_tc++;
                    end
                    2'd3: begin
                        if (acc) begin m_run = 1; m_tc = 0; end
                        else if (m_run && tick && m_tc < int'(dly)) m_tc++;
                    end
                    default: begin m_run = 0; m_tc = 0; end
                endcase
            end
            m_ps    = tick ? 0 : m_ps + 1;
            m_wr    = acc;
            m_widx  = m_fill;
            m_wdata = pop_desc;
            if (m_irq && host_ack) m_fill = 0;
            else if (acc)          m_fill++;
            if (issue) begin
                m_busy = 1;
                m_qid  = base + QID_W'(pick);
                m_rr   = (pick + 1) % NQ;
            end else if (pop_ack) m_busy = 0;
            m_preq = issue;
            m_irq  = irqn;
        end
    end

    // observation, comparison and queue-manager response
    logic [ADDR_W-1:0] list_mem [256];
    int  n_wr = 0, n_irq = 0, n_pop = 0, last_idx = 0, last_wr_cyc = 0, irq_cyc = 0, cyc = 0;
    logic [ADDR_W-1:0] last_data = '0;
    bit  irq_prev = 0;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
        if (!rst) begin
            chk(pop_req == m_preq, "R4 pop_req", pop_req, m_preq);
            if (m_preq) chk(pop_qid == m_qid, "R3 pop_qid", pop_qid, m_qid);
            chk(wr_en == m_wr, "R5 list_wr_en", wr_en, m_wr);
            if (m_wr) begin
                chk(int'(wr_idx) == m_widx, "R5 list_wr_idx", wr_idx, m_widx);
                chk(wr_data == m_wdata, "R5 list_wr_data", wr_data, m_wdata);
            end
            chk(irq == m_irq, "R6 irq", irq, m_irq);
            if (pop_req) n_pop++;
            if (wr_en) begin
                list_mem[wr_idx] = wr_data;
                n_wr++; last_idx = int'(wr_idx); last_data = wr_data; last_wr_cyc = cyc;
            end
            if (irq && !irq_prev) begin n_irq++; irq_cyc = cyc; end
            irq_prev = irq;
            pop_ack = 1'b0; pop_desc = '0;
            if (m_preq) begin
                qm_pend = 1; qm_off = int'(m_qid - base); qm_wait = qm_lat;
            end
            if (qm_pend) begin
                if (qm_wait == 0) begin
                    pop_ack = 1'b1;
                    if (force_null) force_null = 0;
                    else if (qs[qm_off].size() > 0) pop_desc = qs[qm_off].pop_front();
                    qm_pend = 0;
                    refresh();
                end else qm_wait--;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask
    task automatic wait_irq(input int maxc);
        for (int i = 0; i < maxc && !irq; i++) step(1);
    endtask
    task automatic ack();
        host_ack = 1'b1; step(1); host_ack = 1'b0; step(1);
    endtask

    initial begin
        int w0, i0, p0;
        step(4);
        rst = 1'b0;
        step(1);
        chk(pop_req == 0 && wr_en == 0 && irq == 0, "R1 reset outputs", {pop_req, wr_en, irq}, 0);

        // mode 0, full list, round robin across the window
        en = 1'b1;
        w0 = n_wr; p0 = n_pop;
        push(3, 32'hA1); push(3, 32'hA2); push(7, 32'hB1); push(0, 32'hC1);
        wait_irq(200); step(2);
        chk(n_irq == 1, "R6 irq on full", n_irq, 1);
        chk(n_wr - w0 == 4, "R5 writes before full", n_wr - w0, 4);
        chk(n_pop - p0 == 4, "R4 one pop per write", n_pop - p0, 4);
        chk(list_mem[0] == 32'hC1 && list_mem[1] == 32'hA1, "R3 order head", list_mem[1], 32'hA1);
        chk(list_mem[2] == 32'hB1 && list_mem[3] == 32'hA2, "R3 order wrap", list_mem[3], 32'hA2);
        push(1, 32'hD1);
        step(300);
        chk(irq == 1 && n_irq == 1, "R7 irq held", irq, 1);
        chk(n_wr - w0 == 4, "R8 frozen while irq", n_wr - w0, 4);
        ack(); step(10);
        chk(irq == 0, "R7 irq cleared", irq, 0);
        chk(last_idx == 0 && last_data == 32'hD1, "R7 fill restarts at 0", last_idx, 0);
        // acknowledge without irq is ignored
        ack();
        push(9, 32'hE1); push(10, 32'hE2); push(11, 32'hE3);
        wait_irq(100); step(2);
        chk(n_irq == 2 && last_idx == 3, "R7 stray ack ignored", last_idx, 3);
        ack();

        // null pop
        w0 = n_wr;
        force_null = 1; push(2, 32'hF1);
        step(20);
        chk(n_wr - w0 == 1 && last_data == 32'hF1, "R5 null pop discarded", n_wr - w0, 1);
        push(4, 32'hF2); push(5, 32'hF3); push(6, 32'hF4);
        wait_irq(100); step(2);
        chk(n_irq == 3 && last_idx == 3, "R5 null not counted", last_idx, 3);
        ack();

        // single-queue mode
        multi = 1'b0; w0 = n_wr;
        push(5, 32'h51); push(0, 32'h50);
        step(30);
        chk(n_wr - w0 == 1 && last_data == 32'h50, "R2 single queue only", n_wr - w0, 1);
        chk(qs[5].size() == 1, "R2 offset 5 untouched", qs[5].size(), 1);
        multi = 1'b1; step(30);
        chk(last_data == 32'h51, "R2 window restored", last_data, 32'h51);
        push(8, 32'h52); push(8, 32'h53);
        wait_irq(100); ack();

        // mode 0 never times out
        dly = 16'd1; w0 = n_irq;
        push(12, 32'h60);
        step(1000);
        chk(irq == 0 && n_irq == w0, "R10 no timer irq", n_irq, w0);
        push(12, 32'h61); push(12, 32'h62); push(12, 32'h63);
        wait_irq(100); ack();

        // mode 1
        len = 8'd8; mode = 2'd1; dly = 16'd2; i0 = n_irq;
        step(600);
        chk(n_irq == i0, "R11 empty expiry rearms", n_irq, i0);
        w0 = n_wr;
        push(13, 32'h70);
        wait_irq(400); step(1);
        chk(n_irq == i0 + 1 && n_wr - w0 == 1, "R11 expiry with entries", n_irq, i0 + 1);
        ack();

        // mode 2: measured from the first descriptor
        mode = 2'd2; dly = 16'd3;
        push(14, 32'h80);
        step(5); w0 = last_wr_cyc;
        step(55); push(14, 32'h81);
        wait_irq(400); step(1);
        chk((irq_cyc - w0) >= 100 && (irq_cyc - w0) <= 155, "R12 R9 first-packet delay", irq_cyc - w0, 150);
        ack();

        // mode 3: restarted by each descriptor
        mode = 2'd3; dly = 16'd2; i0 = n_irq;
        for (int k = 0; k < 4; k++) begin
            push(15, 32'h90 + k);
            step(40);
        end
        chk(n_irq == i0, "R13 no irq while packets keep coming", n_irq, i0);
        wait_irq(400); step(1);
        chk((irq_cyc - last_wr_cyc) >= 50 && (irq_cyc - last_wr_cyc) <= 105, "R13 last-packet delay", irq_cyc - last_wr_cyc, 100);
        ack();

        // expiry while a pop is in flight
        mode = 2'd2; dly = 16'd1; w0 = n_wr;
        push(16, 32'hB0);
        step(5);
        qm_lat = 150;
        push(17, 32'hB1);
        wait_irq(400); step(1);
        chk(n_wr - w0 == 2, "R14 in-flight entry included", n_wr - w0, 2);
        qm_lat = 0;
        ack(); step(5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule